// File: doc/BRIEF.md
# Serial ADC Power-Mode Controller

This block is the power-state tracker that sits on the device side of a two-channel serial converter link. A fast system clock samples the active-low chip select and the serial clock. The block counts serial-clock falling edges in each frame. From the edge count at which chip select returns high, it decides whether to drop into a shallower or deeper sleep. It also decides when a sleeping converter has been woken by a dummy frame.

A frame opens on the falling edge of chip select. If chip select rises early, the frame is treated as a glitch and has no effect. If it rises inside the abort window, the frame is cut short: the data outputs go to high impedance and the power state steps one level deeper. A frame issued while the block sleeps is a dummy frame. It wakes the block once chip select has stayed low through the commit edge. After a wake, the block reports frames as valid only after a settling interval. For a shallow sleep this interval is a number of serial-clock edges. For a deep sleep it is a number of system-clock cycles.

The outputs are the power mode, an enable for each of the two data outputs, and a flag that tells whether the current frame carries valid data.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: A synchronised falling edge of chip select opens a frame: the edge count restarts at zero and both data-output enables go high within three system clocks, staying high while chip select is low.
- R2: A rising edge of chip select ends the frame and drops both data-output enables within three system clocks, whatever the number of serial-clock edges seen; the remaining serial clocks need not be supplied.
- R3: A frame ended with fewer than 2 serial-clock falling edges leaves the power mode unchanged, in every mode.
- R4: In normal mode (pwr_mode = 2'b00), ending a frame after 2 to 9 falling edges moves the block to partial power-down (pwr_mode = 2'b01). Ending it after 10 or more edges keeps it normal.
- R5: In partial power-down, ending a frame after 2 to 9 falling edges moves the block to full power-down (pwr_mode = 2'b10). The same abort in full power-down leaves it in full power-down.
- R6: In either power-down mode, a frame in which chip select is still low when the 10th falling edge is counted returns the block to normal mode at that edge, without waiting for chip select to rise. A chip-select rise seen in the same sample as the 10th edge also wakes the block.
- R7: After a wake from partial power-down, frames report valid only once 16 serial-clock falling edges have been counted since the dummy frame opened. Edges in later frames count toward the 16.
- R8: After a wake from full power-down, frames that open fewer than FULL_WAKE_CYC system clocks after the dummy frame opened report invalid. Later frames report valid.
- R9: frame_valid is set when a frame opens and holds for that frame. It is 0 for dummy frames and 0 while no frame is open.
- R10: After reset the block is in normal mode with both enables low, frame_valid low, and no settling pending; pwr_mode never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk, idles high |
| pwr_mode | output | 2 | 00 normal, 01 partial power-down, 10 full power-down |
| douta_en | output | 1 | Drive enable for data output A |
| doutb_en | output | 1 | Drive enable for data output B |
| frame_valid | output | 1 | Current frame carries valid data |

## Verification
The bench aims at the edges of the abort window. It uses frames of 0, 1, 2, 9 and 10 falling edges. A design with an off-by-one in the window either powers down on a glitch or misses a true abort. It chains two aborts to reach full power-down and checks that a third abort leaves the block there. A design with the wrong deepening rule would wrap back or wake up.

It drives a chip-select rise in the same sample as the 10th edge of a dummy frame. A design that checks the abort before the commit would send the block deeper instead of waking it. It also cuts a dummy frame short at 10 edges to check that the partial settling count carries into the next frame.

It places frames on both sides of the full-wake interval. A timer that started at the commit edge instead of the chip-select fall would flag the later frame invalid.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_PARTIAL = 2'b01,
    PM_FULL    = 2'b10
  } pwr_mode_t;

  // True when an edge count ends a frame inside the abort window [lo, hi).
  function automatic logic in_abort_window(input int n, input int lo, input int hi);
    return (n >= lo) && (n < hi);
  endfunction

  // One step deeper into sleep; full power-down is the floor.
  function automatic pwr_mode_t deeper(input pwr_mode_t m);
    return (m == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
  endfunction

  // Commit fires on the edge that brings the count to the commit edge.
  function automatic logic hits_commit(input logic fell, input int n, input int commit_at);
    return fell && (n == commit_at);
  endfunction

endpackage

// File: rtl/pm_line_sync.sv
module pm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic lvl_d_o
);
  // Chain of STAGES synchroniser flops plus one history flop for edge detect.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign lvl_o   = chain_q[STAGES-1];
  assign lvl_d_o = chain_q[STAGES];
endmodule

// File: rtl/pm_frame_cnt.sv
module pm_frame_cnt #(
  parameter int FRAME_EDGES = 16,
  localparam int CNT_W = $clog2(FRAME_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             sclk_fall,
  output logic             in_frame,
  output logic [CNT_W-1:0] cnt_now
);
  logic [CNT_W-1:0] cnt_q;

  // Count including an edge seen in this very sample; saturates at a full frame.
  assign cnt_now = (in_frame && sclk_fall && (cnt_q != CNT_W'(FRAME_EDGES)))
                 ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt_q    <= '0;
    end else if (frame_start) begin
      in_frame <= 1'b1;
      cnt_q    <= '0;
    end else begin
      if (frame_end) in_frame <= 1'b0;
      cnt_q <= cnt_now;
    end
  end
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import adc_pwr_pkg::*;
#(
  parameter int FRAME_EDGES   = 16,
  parameter int ABORT_FIRST   = 2,
  parameter int COMMIT_EDGE   = 10,
  parameter int SETTLE_EDGES  = 16,
  parameter int FULL_WAKE_CYC = 400000,
  localparam int CNT_W  = $clog2(FRAME_EDGES + 1),
  localparam int WAKE_MAX = (FULL_WAKE_CYC > SETTLE_EDGES) ? FULL_WAKE_CYC : SETTLE_EDGES,
  localparam int WAKE_W = $clog2(WAKE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             sclk_fall,
  input  logic             in_frame,
  input  logic [CNT_W-1:0] cnt_now,
  output pwr_mode_t        mode_q,
  output logic             valid_q,
  output logic             commit_evt,
  output logic             abort_evt
);
  logic [WAKE_W-1:0] wake_left_q;
  logic              by_edges_q;
  logic              settled;
  logic              wake_tick;

  assign settled    = (wake_left_q == '0);
  assign commit_evt = in_frame && (mode_q != PM_NORMAL)
                   && hits_commit(sclk_fall, int'(cnt_now), COMMIT_EDGE);
  assign abort_evt  = frame_end && in_frame && !commit_evt
                   && in_abort_window(int'(cnt_now), ABORT_FIRST, COMMIT_EDGE);
  assign wake_tick  = by_edges_q ? (sclk_fall && in_frame) : 1'b1;

  // Power mode: commit wins over an abort seen in the same sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= PM_NORMAL;
    else if (commit_evt) mode_q <= PM_NORMAL;
    else if (abort_evt)  mode_q <= deeper(mode_q);
  end

  // Settling tracker: loaded when a dummy frame opens, counted in the unit of that sleep depth.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_left_q <= '0;
      by_edges_q  <= 1'b0;
    end else if (frame_start && mode_q == PM_PARTIAL) begin
      wake_left_q <= WAKE_W'(SETTLE_EDGES);
      by_edges_q  <= 1'b1;
    end else if (frame_start && mode_q == PM_FULL) begin
      wake_left_q <= WAKE_W'(FULL_WAKE_CYC);
      by_edges_q  <= 1'b0;
    end else if (!settled && wake_tick) begin
      wake_left_q <= wake_left_q - 1'b1;
    end
  end

  // Frame validity is decided once, when the frame opens.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           valid_q <= 1'b0;
    else if (frame_start) valid_q <= (mode_q == PM_NORMAL) && settled;
    else if (frame_end)   valid_q <= 1'b0;
  end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FRAME_EDGES   = 16,
  parameter int ABORT_FIRST   = 2,
  parameter int COMMIT_EDGE   = 10,
  parameter int SETTLE_EDGES  = 16,
  parameter int FULL_WAKE_CYC = 400000,
  localparam int CNT_W = $clog2(FRAME_EDGES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sclk_i,
  output logic [1:0] pwr_mode,
  output logic       douta_en,
  output logic       doutb_en,
  output logic       frame_valid
);
  logic cs_lvl, cs_lvl_d, sclk_lvl, sclk_lvl_d;
  logic frame_start, frame_end, sclk_fall;
  logic in_frame, commit_evt, abort_evt, valid_q;
  logic [CNT_W-1:0] cnt_now;
  pwr_mode_t mode_q;

  pm_line_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .line_i(cs_n_i), .lvl_o(cs_lvl), .lvl_d_o(cs_lvl_d)
  );
  pm_line_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sclk_i), .lvl_o(sclk_lvl), .lvl_d_o(sclk_lvl_d)
  );

  // Named events, visible to the bound checker.
  assign frame_start = cs_lvl_d && !cs_lvl;
  assign frame_end   = !cs_lvl_d && cs_lvl;
  assign sclk_fall   = sclk_lvl_d && !sclk_lvl;

  pm_frame_cnt #(.FRAME_EDGES(FRAME_EDGES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .sclk_fall(sclk_fall), .in_frame(in_frame), .cnt_now(cnt_now)
  );

  pm_mode_fsm #(
    .FRAME_EDGES(FRAME_EDGES), .ABORT_FIRST(ABORT_FIRST), .COMMIT_EDGE(COMMIT_EDGE),
    .SETTLE_EDGES(SETTLE_EDGES), .FULL_WAKE_CYC(FULL_WAKE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .sclk_fall(sclk_fall), .in_frame(in_frame), .cnt_now(cnt_now),
    .mode_q(mode_q), .valid_q(valid_q), .commit_evt(commit_evt), .abort_evt(abort_evt)
  );

  assign pwr_mode    = mode_q;
  assign douta_en    = in_frame;
  assign doutb_en    = in_frame;
  assign frame_valid = valid_q;
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk #(
  parameter int CNT_W       = 5,
  parameter int ABORT_FIRST = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pwr_mode,
  input logic             douta_en,
  input logic             doutb_en,
  input logic             frame_valid,
  input logic             frame_start,
  input logic             frame_end,
  input logic             in_frame,
  input logic             commit_evt,
  input logic             abort_evt,
  input logic [CNT_W-1:0] cnt_now
);
  assert_open_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (douta_en && doutb_en));

  assert_close_tristate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!douta_en && !doutb_en));

  assert_glitch_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && in_frame && int'(cnt_now) < ABORT_FIRST) |=> $stable(pwr_mode));

  assert_normal_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && pwr_mode == 2'b00) |=> (pwr_mode == 2'b01));

  assert_partial_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && pwr_mode != 2'b00) |=> (pwr_mode == 2'b10));

  assert_commit_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (pwr_mode == 2'b00));

  assert_dummy_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pwr_mode != 2'b00) |=> !frame_valid);

  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b11);
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk #(.CNT_W(CNT_W), .ABORT_FIRST(ABORT_FIRST)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .douta_en(douta_en), .doutb_en(doutb_en),
  .frame_valid(frame_valid), .frame_start(frame_start), .frame_end(frame_end),
  .in_frame(in_frame), .commit_evt(commit_evt), .abort_evt(abort_evt), .cnt_now(cnt_now)
);

// File: tb/sim_adc_pwr_ctrl.sv
module sim_adc_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FULL_WAKE  = 250;
  localparam int NVEC = 18;

  // Entry: {falling edges in frame (5b), expected mode after frame (2b), expected frame_valid (1b)}
  localparam logic [7:0] VEC [NVEC] = '{
    {5'd16, 2'd0, 1'b1},  // plain frame
    {5'd1,  2'd0, 1'b1},  // R3 glitch in normal
    {5'd2,  2'd1, 1'b1},  // R4 window lower edge
    {5'd1,  2'd1, 1'b0},  // R3 glitch on dummy
    {5'd5,  2'd2, 1'b0},  // R5 partial to full
    {5'd0,  2'd2, 1'b0},  // R3 no edges
    {5'd9,  2'd2, 1'b0},  // R5 full stays full
    {5'd16, 2'd0, 1'b0},  // R6 wake from full
    {5'd16, 2'd0, 1'b0},  // R8 inside wake interval
    {5'd16, 2'd0, 1'b1},  // R8 after wake interval
    {5'd10, 2'd0, 1'b1},  // R4 ten edges is no abort
    {5'd9,  2'd1, 1'b1},  // R4 window upper edge
    {5'd10, 2'd0, 1'b0},  // R6 wake committed at 10
    {5'd16, 2'd0, 1'b0},  // R7 six settle edges left
    {5'd16, 2'd0, 1'b1},  // R7 settled
    {5'd3,  2'd1, 1'b1},  // R4
    {5'd16, 2'd0, 1'b0},  // R6 full dummy from partial
    {5'd16, 2'd0, 1'b1}   // R7 next frame valid
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [1:0] pwr_mode;
  logic douta_en, doutb_en, frame_valid;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_ctrl #(.FULL_WAKE_CYC(FULL_WAKE), .SETTLE_EDGES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .pwr_mode(pwr_mode), .douta_en(douta_en), .doutb_en(doutb_en), .frame_valid(frame_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; wait_cyc(4);
      sclk = 1'b1; wait_cyc(4);
    end
  endtask

  // Opens a frame, samples valid/enables, runs n edges, closes it.
  task automatic run_frame(input int n, output logic v, output logic en);
    cs_n = 1'b0; wait_cyc(4);
    v  = frame_valid;
    en = douta_en && doutb_en;
    pulse_sclk(n);
    cs_n = 1'b1; wait_cyc(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic v, en;
    wait_cyc(3);
    // R10 reset state
    check("R10 mode after reset", pwr_mode, 0);
    check("R10 enable A after reset", douta_en, 0);
    check("R10 enable B after reset", doutb_en, 0);
    check("R10 valid after reset", frame_valid, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R9 valid with no frame", frame_valid, 0);

    for (int k = 0; k < NVEC; k++) begin
      run_frame(int'(VEC[k][7:3]), v, en);
      check($sformatf("R1 enables open vec %0d", k), en, 1);
      check($sformatf("R9 R7 R8 frame_valid vec %0d", k), v, int'(VEC[k][0]));
      check($sformatf("R3 R4 R5 R6 mode vec %0d", k), pwr_mode, int'(VEC[k][2:1]));
      check($sformatf("R2 enables closed vec %0d", k), douta_en | doutb_en, 0);
      check($sformatf("R9 valid idle vec %0d", k), frame_valid, 0);
    end

    // R2: mid-frame abort tri-states both outputs within three clocks
    cs_n = 1'b0; wait_cyc(4);
    pulse_sclk(5);
    cs_n = 1'b1; wait_cyc(4);
    check("R2 enable A after abort", douta_en, 0);
    check("R2 enable B after abort", doutb_en, 0);
    check("R4 mode after abort", pwr_mode, 1);

    // R6: chip select rises in the same sample as the 10th edge of a dummy frame
    cs_n = 1'b0; wait_cyc(4);
    pulse_sclk(9);
    sclk = 1'b0; cs_n = 1'b1; wait_cyc(6);
    sclk = 1'b1; wait_cyc(6);
    check("R6 coincident rise commits", pwr_mode, 0);

    // R6: wake takes effect at the 10th edge while chip select is still low
    run_frame(4, v, en);
    check("R4 re-enter partial", pwr_mode, 1);
    cs_n = 1'b0; wait_cyc(4);
    pulse_sclk(9);
    check("R6 not yet committed at 9", pwr_mode, 1);
    pulse_sclk(1);
    check("R6 committed at 10 with cs low", pwr_mode, 0);
    check("R1 enables held while cs low", douta_en && doutb_en, 1);
    pulse_sclk(6);
    cs_n = 1'b1; wait_cyc(6);
    check("R6 mode stays normal after frame", pwr_mode, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule